// File: doc/BRIEF.md
# Halt Entry and Wake Sequencer

This block decides when a processor core may enter its low-power halt state, when it must leave that state, and whether the interrupt that caused the wake is also acknowledged. After a halt command the core keeps fetching instructions. The stall begins only once the prefetch queue reports full. While the core is halted, clocks and peripherals keep running and all state is retained. Only execution stops.

Waking and acknowledgement are two separate decisions. A non-maskable request, or any unmasked maskable request of any priority, wakes the core. If a handler was already in service when the core halted, only a request that outranks the serviced one is acknowledged. A lower or equal request wakes the core but stays latched as pending. Raw maskable requests are always latched, so a request that arrives masked can wake the core once it is unmasked.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `halted_o`, `wake_o`, `ack_o` and `ack_nmi_o` are 0 and `pend_o` is all zeros.
- R2: A `halt_cmd_i` pulse does not stall the core until `pfq_full_i` is sampled high. `halted_o` rises on the cycle after that sample, and never before it.
- R3: While halted, `nmi_i` sampled high wakes the core and is acknowledged with `ack_nmi_o`=1 and `ack_idx_o`=0.
- R4: While halted, an unmasked maskable request (`irq_mask_i` bit = 0) wakes the core whatever its priority.
- R5: A masked request (mask bit = 1) never wakes the core. Its raw request bit is still latched into `pend_o`.
- R6: With no handler in service (`in_svc_i`=0), the waking request is acknowledged. The one chosen has the smallest priority number among unmasked pending requests, and the lowest index breaks a tie.
- R7: With a handler in service, a waking request whose priority number is greater than or equal to `svc_prio_i` wakes the core without acknowledge, and its `pend_o` bit stays set.
- R8: With a handler in service, a waking request whose priority number is smaller than `svc_prio_i` is acknowledged in the same cycle as `wake_o`, and its `pend_o` bit is cleared.
- R9: `wake_o` and `ack_o` are single-cycle pulses. They appear, and `halted_o` falls, on the cycle after the wake condition is sampled.
- R10: A non-maskable request is acknowledged even while a handler of the highest maskable priority (0) is in service.
- R11: Reset asserted during halt returns the block to running, clears every pending flag and gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_cmd_i | input | 1 | Halt command strobe |
| pfq_full_i | input | 1 | Prefetch queue full flag |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_req_i | input | N_IRQ | Raw maskable requests |
| irq_mask_i | input | N_IRQ | Mask bits, 1 = masked |
| irq_prio_i | input | N_IRQ*PRIO_W | Priority level per request, field i at bits [i*PRIO_W +: PRIO_W], 0 = highest |
| in_svc_i | input | 1 | A handler is in service |
| svc_prio_i | input | PRIO_W | Priority of the request being serviced |
| halted_o | output | 1 | Core stalled in halt |
| wake_o | output | 1 | One-cycle wake pulse |
| ack_o | output | 1 | One-cycle acknowledge strobe |
| ack_nmi_o | output | 1 | Acknowledge is for the non-maskable request |
| ack_idx_o | output | IDX_W | Index of the acknowledged maskable request |
| pend_o | output | N_IRQ | Retained pending flags |

## Verification
The assertions assume that `in_svc_i`, `svc_prio_i` and the priority fields hold steady across the cycle in which a wake is sampled, because the acknowledge check compares against the values sampled one cycle earlier. They also assume that `pfq_full_i` is only meaningful after a halt command. The stimulus changes the handler state and the priorities only while the core runs or before it halts, and it raises the queue-full flag only after a command pulse. Requests are pulsed or held for single cycles so that latching and retention both appear at the ports.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  typedef enum logic [1:0] {
    HW_RUN   = 2'd0,
    HW_DRAIN = 2'd1,
    HW_HALT  = 2'd2
  } hw_state_e;
endpackage

// File: rtl/hw_seq.sv
module hw_seq
  import halt_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic pfq_full,
  input  logic wake_req,
  output logic wake_fire,
  output logic halted,
  output logic wake_pulse
);
  hw_state_e state_q, state_d;

  assign wake_fire = (state_q == HW_HALT) && wake_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HW_RUN:   if (halt_cmd) state_d = HW_DRAIN;
      HW_DRAIN: if (pfq_full) state_d = HW_HALT;
      HW_HALT:  if (wake_req) state_d = HW_RUN;
      default:  state_d = HW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= HW_RUN;
      wake_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      wake_pulse <= wake_fire;
    end
  end

  assign halted = (state_q == HW_HALT);

  // R2
  halt_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(pfq_full));

  // R9
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R9
  wake_drops_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!halted && $past(halted)));
endmodule

// File: rtl/hw_pend.sv
module hw_pend #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] req,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N_IRQ-1:0] pend_q,
  output logic [N_IRQ-1:0] eff
);
  logic [N_IRQ-1:0] clr_vec;

  assign eff = pend_q | req;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= eff & ~clr_vec;
  end

  // R5
  req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0 && !clr_en) |=> ((pend_q & $past(req)) == $past(req)));
endmodule

// File: rtl/hw_arb.sv
module hw_arb #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]        eff,
  input  logic [N_IRQ-1:0]        mask,
  input  logic [N_IRQ*PRIO_W-1:0] prio,
  input  logic                    nmi,
  input  logic                    in_svc,
  input  logic [PRIO_W-1:0]       svc_prio,
  output logic                    any_open,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    grant
);
  logic [PRIO_W-1:0] best_pr;

  function automatic logic [PRIO_W-1:0] level_of(input logic [N_IRQ*PRIO_W-1:0] v, input int i);
    return v[i*PRIO_W +: PRIO_W];
  endfunction

  function automatic logic outranks(input logic [PRIO_W-1:0] cand, input logic [PRIO_W-1:0] cur);
    return cand < cur;
  endfunction

  always_comb begin
    any_open = 1'b0;
    sel_idx  = '0;
    best_pr  = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (eff[i] && !mask[i] && (!any_open || outranks(level_of(prio, i), best_pr))) begin
        any_open = 1'b1;
        sel_idx  = IDX_W'(i);
        best_pr  = level_of(prio, i);
      end
    end
    grant = nmi || (any_open && (!in_svc || outranks(best_pr, svc_prio)));
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    halt_cmd_i,
  input  logic                    pfq_full_i,
  input  logic                    nmi_i,
  input  logic [N_IRQ-1:0]        irq_req_i,
  input  logic [N_IRQ-1:0]        irq_mask_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic                    in_svc_i,
  input  logic [PRIO_W-1:0]       svc_prio_i,
  output logic                    halted_o,
  output logic                    wake_o,
  output logic                    ack_o,
  output logic                    ack_nmi_o,
  output logic [IDX_W-1:0]        ack_idx_o,
  output logic [N_IRQ-1:0]        pend_o
);
  logic [N_IRQ-1:0] eff;
  logic             any_open;
  logic [IDX_W-1:0] sel_idx;
  logic             grant;
  logic             wake_req;
  logic             wake_fire;
  logic             ack_fire;
  logic             clr_en;

  function automatic logic [PRIO_W-1:0] prio_at(input logic [N_IRQ*PRIO_W-1:0] v, input logic [IDX_W-1:0] idx);
    return v[int'(idx)*PRIO_W +: PRIO_W];
  endfunction

  assign wake_req = nmi_i | any_open;
  assign ack_fire = wake_fire & grant;
  assign clr_en   = ack_fire & ~nmi_i;

  hw_pend #(.N_IRQ(N_IRQ)) pend_i (
    .clk(clk), .rst_n(rst_n), .req(irq_req_i),
    .clr_en(clr_en), .clr_idx(sel_idx), .pend_q(pend_o), .eff(eff)
  );

  hw_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) arb_i (
    .eff(eff), .mask(irq_mask_i), .prio(irq_prio_i), .nmi(nmi_i),
    .in_svc(in_svc_i), .svc_prio(svc_prio_i),
    .any_open(any_open), .sel_idx(sel_idx), .grant(grant)
  );

  hw_seq seq_i (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd_i), .pfq_full(pfq_full_i),
    .wake_req(wake_req), .wake_fire(wake_fire), .halted(halted_o), .wake_pulse(wake_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o     <= 1'b0;
      ack_nmi_o <= 1'b0;
      ack_idx_o <= '0;
    end else begin
      ack_o     <= ack_fire;
      ack_nmi_o <= ack_fire & nmi_i;
      ack_idx_o <= (ack_fire && !nmi_i) ? sel_idx : '0;
    end
  end

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R8
  ack_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> wake_o);

  // R7
  ack_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_nmi_o && $past(in_svc_i)) |-> (prio_at($past(irq_prio_i), ack_idx_o) < $past(svc_prio_i)));

  // R8
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_nmi_o) |-> !pend_o[ack_idx_o]);

  // R5
  masked_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !nmi_i && (((irq_req_i | pend_o) & ~irq_mask_i) == '0)) |=> !wake_o);

  // R3
  nmi_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_nmi_o |-> (ack_o && ack_idx_o == '0));
endmodule

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 0, pfq_full = 0, nmi = 0, in_svc = 0;
  logic [N-1:0] req = '0, mask = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] svc_prio = '0;
  logic halted, wake, ack, ack_nmi;
  logic [IW-1:0] ack_idx;
  logic [N-1:0] pend;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  halt_wake_ctrl #(.N_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_cmd_i(halt_cmd), .pfq_full_i(pfq_full),
    .nmi_i(nmi), .irq_req_i(req), .irq_mask_i(mask), .irq_prio_i(prio),
    .in_svc_i(in_svc), .svc_prio_i(svc_prio),
    .halted_o(halted), .wake_o(wake), .ack_o(ack), .ack_nmi_o(ack_nmi),
    .ack_idx_o(ack_idx), .pend_o(pend)
  );

  // Reference model: 0 running, 1 waiting for full queue, 2 halted
  int m_mode = 0;
  bit m_halted = 0, m_wake = 0, m_ack = 0, m_nmi = 0;
  int m_idx = 0;
  bit m_pend[N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_halted = 0; m_wake = 0; m_ack = 0; m_nmi = 0; m_idx = 0;
      foreach (m_pend[k]) m_pend[k] = 0;
    end else begin
      bit live[N];
      bit any;
      int pick, lvl;
      m_wake = 0; m_ack = 0; m_nmi = 0; m_idx = 0;
      any = 0; pick = -1; lvl = 0;
      for (int k = 0; k < N; k++) begin
        live[k] = (m_pend[k] || req[k]) && !mask[k];
        if (live[k]) any = 1;
      end
      for (int l = 0; l < (1 << PW) && pick < 0; l++)
        for (int k = 0; k < N && pick < 0; k++)
          if (live[k] && int'(prio[k*PW +: PW]) == l) begin pick = k; lvl = l; end
      for (int k = 0; k < N; k++) if (req[k]) m_pend[k] = 1;
      if (m_mode == 0) begin
        if (halt_cmd) m_mode = 1;
      end else if (m_mode == 1) begin
        if (pfq_full) m_mode = 2;
      end else if (nmi || any) begin
        m_mode = 0;
        m_wake = 1;
        if (nmi) begin
          m_ack = 1; m_nmi = 1;
        end else if (!in_svc || lvl < int'(svc_prio)) begin
          m_ack = 1; m_idx = pick; m_pend[pick] = 0;
        end
      end
      m_halted = (m_mode == 2);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int mp;
      mp = 0;
      for (int k = 0; k < N; k++) if (m_pend[k]) mp |= (1 << k);
      chk("halted", int'(halted), int'(m_halted));
      chk("wake R9", int'(wake), int'(m_wake));
      chk("ack R9", int'(ack), int'(m_ack));
      chk("ack_nmi", int'(ack_nmi), int'(m_nmi));
      if (m_ack) chk("ack_idx", int'(ack_idx), m_idx);
      chk("pend", int'(pend), mp);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_halt();
    halt_cmd = 1; cyc(); halt_cmd = 0;
    cyc(2);
    pfq_full = 1; cyc(); pfq_full = 0;
    cyc();
  endtask

  task automatic set_prio(input int i, input int p);
    prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) set_prio(k, 7 - k);
    cur_req = "R1"; cyc(3); rst_n = 1; cyc(2);

    cur_req = "R2"; do_halt(); cyc(2);

    cur_req = "R5"; mask = '1; req[2] = 1; cyc(); req = '0; cyc(3);

    cur_req = "R4"; mask = '0; cyc(3);

    cur_req = "R6";
    set_prio(5, 1); set_prio(3, 1); set_prio(1, 4);
    do_halt(); req = 8'b0010_1010; cyc(); req = '0; cyc(3);
    do_halt(); cyc(2); do_halt(); cyc(2);

    cur_req = "R7";
    in_svc = 1; svc_prio = 3'd2; set_prio(4, 5);
    do_halt(); req[4] = 1; cyc(); req = '0; cyc(3);
    mask[4] = 1; set_prio(6, 2);
    do_halt(); req[6] = 1; cyc(); req = '0; cyc(3);
    mask[6] = 1;

    cur_req = "R8";
    svc_prio = 3'd3; set_prio(0, 1);
    do_halt(); req[0] = 1; cyc(); req = '0; cyc(3);

    cur_req = "R10";
    svc_prio = 3'd0;
    do_halt(); nmi = 1; cyc(); nmi = 0; cyc(3);

    cur_req = "R3";
    in_svc = 0;
    do_halt(); nmi = 1; req[7] = 1; mask[7] = 1; cyc(); nmi = 0; req = '0; cyc(3);

    cur_req = "R11";
    mask = '1; req = 8'b0101_0011; cyc(); req = '0;
    do_halt(); cyc(2);
    rst_n = 0; cyc(2); rst_n = 1; cyc(3);
    mask = '0; cyc(3);

    finish_run();
  end
endmodule